// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a GPIO controller that software reaches through a plain 32-bit register bus. Pins are grouped 32 to a bank, and pin n sits in bank n/32 at bit n mod 32. There are at most three banks. Each present bank holds three registers. The function register marks a pin as general purpose (1) or as belonging to a native function (0). The direction register makes a pin an input (1) or an output (0). The level register holds the output latch and returns the pin state when read.

The block drives each pin's output value and output enable, and it samples each pin's input through a two-stage synchronizer. Three per-pin masks, fixed at build time, describe what each pin can do:
- Input-only pins keep their direction bit at 1.
- Output-only pins keep their direction bit at 0.
- Pins with a fixed function bit always read 0 in the function register, yet still behave as general-purpose pins.

A pin-count parameter and a bank-enable parameter decide which banks exist. A software driver can therefore write a direction bit and read it back to learn whether the change took effect.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The registers sit at these byte offsets. Bank 0: function 0x00, direction 0x04, level 0x0C. Bank 1: 0x30, 0x34, 0x38. Bank 2: 0x40, 0x44, 0x48. A write with `bus_we` high takes effect at the clock edge, and `bus_rdata` shows the addressed register combinationally. No register changes without a write.
- R2: Direction bit 1 makes a pin an input and 0 makes it an output. `pin_oe` for a pin is high only when its effective function bit is 1 and its direction bit is 0.
- R3: Input-only pins always read direction 1 and output-only pins always read direction 0. Writes to those bits are ignored. If a pin is in both masks, input-only wins. An input-only pin never asserts `pin_oe`.
- R4: A pin in the fixed-function mask reads 0 in its function bit and ignores writes to it. It still counts as a GPIO pin (effective function 1) when `pin_oe` is formed.
- R5: For an input pin, a level read returns the synchronized input. For an output pin, it returns the output latch. A level write changes only the latch, and `pin_out` always equals the latch.
- R6: A change on `pin_in` shows in a level read after the second rising clock edge, and not after the first.
- R7: Certain accesses read 0 and change no state:
  - an offset of a bank that is disabled or lies beyond the pin count;
  - any other unmapped or unaligned offset.
  In addition, bits for pins at or above the pin count read 0.
- R8: Reset has these effects:
  - Function bits clear to 0.
  - Level latches clear to 0.
  - Every direction bit reads 1, except output-only bits, which read 0.
  - `pin_oe` is all 0.
- R9: A level write can land in the same cycle that an input pin changes. In that case input bits still report the synchronized pin and not the written value. The written value becomes visible once the direction turns the pin into an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | NUM_PINS | Pin inputs |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |

## Verification
A level-register write and a change on an input pin can fall in the same cycle. The latch takes the bus data while the synchronizer takes the new pin value. The bench provokes this by driving a new `pin_in` pattern on the same edge as a write to the level register of a bank whose pins are mostly inputs. Two edges later it judges the level read: input bits must show the new pin pattern, and only output-only bits may show the written data. The bench then turns the bank to outputs and expects both the read and `pin_out` to show the written latch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_W    = 32;
  localparam int MAX_BANKS = 3;
  localparam int ALL_W     = BANK_W * MAX_BANKS;
  localparam int ADDR_W    = 8;

  typedef enum logic [1:0] {
    REG_FUNC = 2'd0,
    REG_DIR  = 2'd1,
    REG_LVL  = 2'd2
  } reg_kind_e;

  // Byte offset of register kind k in bank b. Bank 0 leaves a gap before
  // its level register; banks 1 and 2 are packed at 0x30 + 0x10*(b-1).
  function automatic logic [ADDR_W-1:0] reg_offset(input int b, input int k);
    int off;
    if (b == 0) off = (k == 2) ? 12 : 4 * k;
    else        off = 48 + 16 * (b - 1) + 4 * k;
    return ADDR_W'(off);
  endfunction

  function automatic logic bank_present(input logic [MAX_BANKS-1:0] en,
                                        input int npins, input int b);
    return en[b] && (npins > BANK_W * b);
  endfunction

  // One bit per pin that exists and lies in an enabled bank.
  function automatic logic [ALL_W-1:0] live_mask(input logic [MAX_BANKS-1:0] en,
                                                 input int npins);
    logic [ALL_W-1:0] m;
    m = '0;
    for (int i = 0; i < ALL_W; i++)
      m[i] = en[i / BANK_W] && (i < npins);
    return m;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter logic [MAX_BANKS-1:0] BANK_EN  = 3'b111,
  parameter int                   NUM_PINS = 76
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [1:0]        bank,
  output reg_kind_e         kind
);
  always_comb begin
    hit  = 1'b0;
    bank = 2'd0;
    kind = REG_FUNC;
    for (int b = 0; b < MAX_BANKS; b++) begin
      for (int k = 0; k < 3; k++) begin
        if (bank_present(BANK_EN, NUM_PINS, b) && addr == reg_offset(b, k)) begin
          hit  = 1'b1;
          bank = 2'(b);
          kind = reg_kind_e'(k);
        end
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] PIN_MASK   = '1,
  parameter logic [BANK_W-1:0] IN_ONLY    = '0,
  parameter logic [BANK_W-1:0] OUT_ONLY   = '0,
  parameter logic [BANK_W-1:0] FUNC_FIXED = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_func,
  input  logic              we_dir,
  input  logic              we_lvl,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] pin_in,
  output logic [BANK_W-1:0] func_rd,
  output logic [BANK_W-1:0] dir_rd,
  output logic [BANK_W-1:0] lvl_rd,
  output logic [BANK_W-1:0] pin_out,
  output logic [BANK_W-1:0] pin_oe,
  output logic [BANK_W-1:0] in_sync
);
  localparam logic [BANK_W-1:0] IN_M     = IN_ONLY & PIN_MASK;
  localparam logic [BANK_W-1:0] OUT_M    = OUT_ONLY & PIN_MASK & ~IN_M;
  localparam logic [BANK_W-1:0] DIR_WR   = PIN_MASK & ~IN_M & ~OUT_M;
  localparam logic [BANK_W-1:0] FUNC_WR  = PIN_MASK & ~FUNC_FIXED;
  localparam logic [BANK_W-1:0] FUNC_ONE = PIN_MASK & FUNC_FIXED;

  logic [BANK_W-1:0] func_q, dir_q, lvl_q, sync1_q, sync2_q;
  logic [BANK_W-1:0] func_eff, dir_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q  <= '0;
      dir_q   <= DIR_WR;
      lvl_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (we_func) func_q <= wdata & FUNC_WR;
      if (we_dir)  dir_q  <= wdata & DIR_WR;
      if (we_lvl)  lvl_q  <= wdata & PIN_MASK;
      sync1_q <= pin_in & PIN_MASK;
      sync2_q <= sync1_q;
    end
  end

  assign func_eff = func_q | FUNC_ONE;
  assign dir_eff  = (dir_q & DIR_WR) | IN_M;

  assign func_rd  = func_q;
  assign dir_rd   = dir_eff;
  assign lvl_rd   = ((dir_eff & sync2_q) | (~dir_eff & lvl_q)) & PIN_MASK;
  assign pin_out  = lvl_q;
  assign pin_oe   = func_eff & ~dir_eff & PIN_MASK;
  assign in_sync  = sync2_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int                   NUM_PINS   = 76,
  parameter logic [MAX_BANKS-1:0] BANK_EN    = 3'b111,
  parameter logic [ALL_W-1:0]     IN_ONLY    = {32'h0000_0008, 32'h0000_0000, 32'h0000_0F00},
  parameter logic [ALL_W-1:0]     OUT_ONLY   = {32'h0000_0020, 32'h0000_0000, 32'hF000_0000},
  parameter logic [ALL_W-1:0]     FUNC_FIXED = {32'h0000_0000, 32'h0001_0000, 32'h0013_0000}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam logic [ALL_W-1:0] LIVE = live_mask(BANK_EN, NUM_PINS);

  logic              addr_hit;
  logic [1:0]        addr_bank;
  reg_kind_e         addr_kind;
  logic [ALL_W-1:0]  pin_pad, out_all, oe_all, dir_all, in_sync_all;
  logic [BANK_W-1:0] func_rd_a [MAX_BANKS];
  logic [BANK_W-1:0] dir_rd_a  [MAX_BANKS];
  logic [BANK_W-1:0] lvl_rd_a  [MAX_BANKS];

  assign pin_pad = ALL_W'(pin_in);

  gpio_addr_decode #(.BANK_EN(BANK_EN), .NUM_PINS(NUM_PINS)) u_dec (
    .addr(bus_addr), .hit(addr_hit), .bank(addr_bank), .kind(addr_kind)
  );

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (bank_present(BANK_EN, NUM_PINS, b)) begin : g_on
      logic sel;
      assign sel = bus_we && addr_hit && (addr_bank == 2'(b));
      gpio_bank #(
        .PIN_MASK  (LIVE[b*BANK_W +: BANK_W]),
        .IN_ONLY   (IN_ONLY[b*BANK_W +: BANK_W]),
        .OUT_ONLY  (OUT_ONLY[b*BANK_W +: BANK_W]),
        .FUNC_FIXED(FUNC_FIXED[b*BANK_W +: BANK_W])
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_func (sel && addr_kind == REG_FUNC),
        .we_dir  (sel && addr_kind == REG_DIR),
        .we_lvl  (sel && addr_kind == REG_LVL),
        .wdata   (bus_wdata),
        .pin_in  (pin_pad[b*BANK_W +: BANK_W]),
        .func_rd (func_rd_a[b]),
        .dir_rd  (dir_rd_a[b]),
        .lvl_rd  (lvl_rd_a[b]),
        .pin_out (out_all[b*BANK_W +: BANK_W]),
        .pin_oe  (oe_all[b*BANK_W +: BANK_W]),
        .in_sync (in_sync_all[b*BANK_W +: BANK_W])
      );
      assign dir_all[b*BANK_W +: BANK_W] = dir_rd_a[b];
    end else begin : g_off
      assign func_rd_a[b] = '0;
      assign dir_rd_a[b]  = '0;
      assign lvl_rd_a[b]  = '0;
      assign out_all[b*BANK_W +: BANK_W]     = '0;
      assign oe_all[b*BANK_W +: BANK_W]      = '0;
      assign in_sync_all[b*BANK_W +: BANK_W] = '0;
      assign dir_all[b*BANK_W +: BANK_W]     = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_hit) begin
      unique case (addr_kind)
        REG_FUNC: bus_rdata = func_rd_a[addr_bank];
        REG_DIR:  bus_rdata = dir_rd_a[addr_bank];
        REG_LVL:  bus_rdata = lvl_rd_a[addr_bank];
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_all[NUM_PINS-1:0];
  assign pin_oe  = oe_all[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter logic [ALL_W-1:0] LIVE    = '1,
  parameter logic [ALL_W-1:0] IN_MASK = '0,
  parameter logic [ALL_W-1:0] OUT_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [BANK_W-1:0] bus_rdata,
  input logic              addr_hit,
  input logic [ALL_W-1:0]  dir_all,
  input logic [ALL_W-1:0]  oe_all,
  input logic [ALL_W-1:0]  out_all,
  input logic [ALL_W-1:0]  pin_pad,
  input logic [ALL_W-1:0]  in_sync_all
);
  localparam logic [ALL_W-1:0] IN_L  = IN_MASK & LIVE;
  localparam logic [ALL_W-1:0] OUT_L = OUT_MASK & LIVE & ~IN_L;

  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  AST_REG_HOLD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(dir_all)); // R1
  AST_REG_HOLD_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(out_all)); // R5
  AST_IN_ONLY_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_all & IN_L) == IN_L); // R3
  AST_OUT_ONLY_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_all & OUT_L) == '0); // R3
  AST_OE_NOT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_all & (IN_L | ~LIVE)) == '0); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> bus_rdata == '0); // R7
  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd2) |-> in_sync_all == ($past(pin_pad, 2) & LIVE)); // R6
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .LIVE(LIVE), .IN_MASK(IN_ONLY), .OUT_MASK(OUT_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .addr_hit(addr_hit), .dir_all(dir_all), .oe_all(oe_all), .out_all(out_all),
  .pin_pad(pin_pad), .in_sync_all(in_sync_all)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int         NP  = 76;
  localparam logic [2:0] BEN = 3'b101;
  localparam logic [95:0] IN_M  = {32'h0000_0008, 32'h0000_0000, 32'h0000_0F00};
  localparam logic [95:0] OUT_M = {32'h0000_0020, 32'h0000_0000, 32'hF000_0000};
  localparam logic [95:0] FIX_M = {32'h0000_0000, 32'h0001_0000, 32'h0013_0000};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_func [3];
  logic [31:0] m_dir  [3];
  logic [31:0] m_lvl  [3];
  logic [95:0] pin_sync;   // pin value the design has had time to synchronize

  always #10 clk = ~clk;

  gpio_bank_ctrl #(
    .NUM_PINS(NP), .BANK_EN(BEN), .IN_ONLY(IN_M), .OUT_ONLY(OUT_M), .FUNC_FIXED(FIX_M)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] vmask(int b);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) m[i] = BEN[b] && (32 * b + i < NP);
    return m;
  endfunction

  function automatic logic [31:0] sl(logic [95:0] v, int b);
    return v[32 * b +: 32];
  endfunction

  // dir reads 1 for input-only, 0 for output-only (input-only wins)
  function automatic logic [31:0] dir_fix(logic [31:0] w, int b);
    logic [31:0] i = sl(IN_M, b);
    logic [31:0] o = sl(OUT_M, b) & ~i;
    return ((w & ~o) | i) & vmask(b);
  endfunction

  function automatic logic [31:0] exp_lvl(int b);
    return ((m_dir[b] & sl(pin_sync, b)) | (~m_dir[b] & m_lvl[b])) & vmask(b);
  endfunction

  // returns bank*4+kind, or -1 when the offset is not mapped in this build
  function automatic int map_of(logic [7:0] a);
    case (a)
      8'h00: return 0;  8'h04: return 1;  8'h0C: return 2;
      8'h40: return 8;  8'h44: return 9;  8'h48: return 10;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    int m;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    m = map_of(a);
    if (m >= 0) begin
      case (m % 4)
        0: m_func[m / 4] = d & vmask(m / 4) & ~sl(FIX_M, m / 4);
        1: m_dir[m / 4]  = dir_fix(d, m / 4);
        default: m_lvl[m / 4] = d & vmask(m / 4);
      endcase
    end
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #2;
    chk(req, {64'b0, bus_rdata}, {64'b0, exp});
  endtask

  task automatic pins_chk(string req);
    logic [95:0] eo, ee;
    for (int b = 0; b < 3; b++) begin
      eo[32 * b +: 32] = m_lvl[b] & vmask(b);
      ee[32 * b +: 32] = (m_func[b] | sl(FIX_M, b)) & ~m_dir[b] & vmask(b);
    end
    chk({req, " pin_out"}, 96'(pin_out), eo);
    chk({req, " pin_oe"},  96'(pin_oe),  ee);
  endtask

  task automatic regs_chk(string req);
    rd_chk(req, 8'h00, m_func[0]); rd_chk(req, 8'h04, m_dir[0]); rd_chk(req, 8'h0C, exp_lvl(0));
    rd_chk(req, 8'h40, m_func[2]); rd_chk(req, 8'h44, m_dir[2]); rd_chk(req, 8'h48, exp_lvl(2));
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pats [5];
    logic [7:0]  offs [6];
    pats = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h1234_5678};
    offs = '{8'h00, 8'h04, 8'h0C, 8'h40, 8'h44, 8'h48};
    for (int b = 0; b < 3; b++) begin
      m_func[b] = '0;
      m_lvl[b]  = '0;
      m_dir[b]  = dir_fix(32'hFFFF_FFFF, b) & ~(sl(OUT_M, b) & ~sl(IN_M, b));
    end
    pin_sync = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    regs_chk("R8 reset");
    pins_chk("R8 reset");

    // R1 R2 R3 R4 R5: sweep patterns through every mapped register
    pin_in = {12'hA5C, 32'h0F0F_3C3C, 32'hDEAD_BEEF};
    pin_sync = 96'(pin_in);
    repeat (3) @(negedge clk);
    for (int p = 0; p < 5; p++) begin
      for (int o = 0; o < 6; o++) begin
        wr(offs[o], pats[p] ^ {24'b0, offs[o]});
        regs_chk("R1/R3/R4/R5 sweep");
        pins_chk("R2/R4 sweep");
      end
    end

    // R4: fixed function bit still lets pin 17 drive as GPIO
    wr(8'h00, 32'h0000_0000);
    wr(8'h04, 32'h0000_0000);
    wr(8'h0C, 32'h0002_0000);
    rd_chk("R4 fixed reads 0", 8'h00, 32'h0);
    checks++;
    if (pin_oe[17] !== 1'b1 || pin_out[17] !== 1'b1) begin
      errors++;
      $display("FAIL R4 pin17 oe/out actual=%b%b expected=11", pin_oe[17], pin_out[17]);
    end
    pins_chk("R4 fixed");

    // R7: unmapped / disabled-bank offsets read 0 and change nothing
    for (int a = 0; a < 256; a++) begin
      if (map_of(8'(a)) < 0) begin
        wr(8'(a), 32'hFFFF_FFFF);
        rd_chk("R7 unmapped", 8'(a), 32'h0);
      end
    end
    regs_chk("R7 state kept");
    pins_chk("R7 state kept");

    // R6: two-flop synchronizer latency on bank 0
    wr(8'h04, 32'hFFFF_FFFF);
    pin_in = '0;
    repeat (3) @(negedge clk);
    pin_sync = '0;
    pin_in[31:0] = 32'h00C3_0055;
    rd_chk("R6 one edge old", 8'h0C, exp_lvl(0));
    pin_sync = 96'(pin_in);
    rd_chk("R6 two edges new", 8'h0C, exp_lvl(0));

    // R9: level write and input change in the same cycle, bank 2
    wr(8'h44, 32'hFFFF_FFFF);
    @(negedge clk);
    bus_addr = 8'h48; bus_wdata = 32'h0000_0F5A; bus_we = 1'b1;
    pin_in[75:64] = 12'h3A6;
    @(negedge clk);
    bus_we = 1'b0;
    m_lvl[2] = 32'h0000_0F5A & vmask(2);
    pin_sync = 96'(pin_in);
    rd_chk("R9 input wins", 8'h48, exp_lvl(2));
    pins_chk("R9 latch");
    wr(8'h44, 32'h0000_0000);
    rd_chk("R9 latch visible", 8'h48, 32'h0000_0F5A & ~sl(IN_M, 2) | (sl(IN_M, 2) & sl(pin_sync, 2)));
    pins_chk("R9 out");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule